// File: doc/BRIEF.md
# Masked Compare Poll and Conditional Write Engine

This block carries out two kinds of command issued by a command processor. Both read one 32-bit poll value from either a register space or a memory space. Both then AND the poll value and a reference with a mask and test the two results with one of eight compare codes. In wait mode the engine reads again and again until the compare holds, with a programmable pause after each failed read. In conditional-write mode it reads once and, if the compare holds, issues one 32-bit write to register or memory space.

A command is taken in one cycle while `cmd_ready_o` is high. The register space and the memory space each have a plain request/acknowledge port. A request stays up until the matching acknowledge arrives. When the command finishes, `done_o` pulses for one cycle. Addresses leave the block untranslated.

Top module: `poll_cond_unit`

## Requirements
- R1: The compare code sits in control bits 2:0. The unsigned tests are: 0 always true, 1 poll<ref, 2 poll<=ref, 3 equal, 4 not equal, 5 poll>=ref, 6 poll>ref.
- R2: Compare code 7 never holds. A conditional write with code 7 never writes, whatever the data.
- R3: The poll value and the reference are both ANDed with the mask before the compare, so bits outside the mask never affect the result.
- R4: Control bit 4 selects the poll space, 0 for register and 1 for memory. A register address is bits 15:0 of the poll address low word.
- R5: A memory address is 48 bits wide. Bits 31:0 are the low word with bits 1:0 forced to zero. Bits 47:32 are bits 15:0 of the high word. This rule holds for both the poll address and the write address.
- R6: In conditional-write mode (`cmd_mode_i`=1), control bit 8 selects the write space, 0 for register and 1 for memory. A true compare causes exactly one write of `wr_data_i` to the formed address.
- R7: A conditional write whose compare fails still finishes with a `done_o` pulse and issues no write.
- R8: In wait mode (`cmd_mode_i`=0), the engine repeats the poll read until the compare holds. It then pulses `done_o` and never writes.
- R9: In wait mode, after a read whose compare fails, the poll request stays low for exactly `interval_i`+2 cycles, counted from the cycle after the acknowledge.
- R10: At most one of the two space requests is high at a time. A request, with its address, holds steady until it is acknowledged.
- R11: After reset, `cmd_ready_o` is 1, both requests are 0 and `done_o` is 0. `done_o` lasts exactly one cycle, and every return to ready comes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken when ready |
| cmd_ready_o | output | 1 | Engine idle, can take a command |
| cmd_mode_i | input | 1 | 0 wait mode, 1 conditional write |
| cmd_ctrl_i | input | 32 | Control word: compare code, poll space, write space |
| poll_lo_i | input | 32 | Poll address low word |
| poll_hi_i | input | 32 | Poll address high word |
| ref_i | input | 32 | Reference value |
| mask_i | input | 32 | Compare mask |
| interval_i | input | 16 | Pause cycles after a failed wait read |
| wr_lo_i | input | 32 | Write address low word |
| wr_hi_i | input | 32 | Write address high word |
| wr_data_i | input | 32 | Write data |
| reg_req_o | output | 1 | Register space request |
| reg_we_o | output | 1 | Register request is a write |
| reg_addr_o | output | 16 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_ack_i | input | 1 | Register acknowledge |
| reg_rdata_i | input | 32 | Register read data |
| mem_req_o | output | 1 | Memory space request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 48 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every compare code is tried with the poll value below, equal to and above the reference. These three points separate each relational test from its neighbours, for example less-than from less-or-equal, and show that code 7 stays false. A pair of values with the top bit set, differing only outside the mask, shows whether the compare is unsigned and whether the mask is applied. Address words with junk in their upper and lowest bits show whether each space forms its address correctly. Wait-mode runs give false results for a set number of reads before a true one, with non-zero and zero pauses, and count the reads and the idle gap between them.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    CMP_ALWAYS = 3'd0,
    CMP_LT     = 3'd1,
    CMP_LE     = 3'd2,
    CMP_EQ     = 3'd3,
    CMP_NE     = 3'd4,
    CMP_GE     = 3'd5,
    CMP_GT     = 3'd6,
    CMP_NEVER  = 3'd7
  } cmp_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_PAUSE,
    ST_WRITE
  } pcu_state_e;

  localparam int unsigned FN_LSB        = 0;
  localparam int unsigned FN_W          = 3;
  localparam int unsigned POLL_SPACE_BIT = 4;
  localparam int unsigned WR_SPACE_BIT   = 8;
  localparam logic        MODE_WAIT     = 1'b0;
  localparam logic        MODE_CWRITE   = 1'b1;
endpackage

// File: rtl/pcu_compare.sv
module pcu_compare
  import pcu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  cmp_fn_e             fn_i,
  input  logic [DATA_W-1:0]   poll_i,
  input  logic [DATA_W-1:0]   ref_i,
  input  logic [DATA_W-1:0]   mask_i,
  output logic                hit_o
);
  logic [DATA_W-1:0] a, b;
  assign a = poll_i & mask_i;
  assign b = ref_i & mask_i;

  always_comb begin
    unique case (fn_i)
      CMP_ALWAYS: hit_o = 1'b1;
      CMP_LT:     hit_o = a <  b;
      CMP_LE:     hit_o = a <= b;
      CMP_EQ:     hit_o = a == b;
      CMP_NE:     hit_o = a != b;
      CMP_GE:     hit_o = a >= b;
      CMP_GT:     hit_o = a >  b;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcu_addr_form.sv
module pcu_addr_form #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 16,
  parameter int unsigned MEM_AW = 48
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [MEM_AW-1:0] mem_addr_o
);
  localparam int unsigned HI_W = MEM_AW - DATA_W;

  assign reg_addr_o = lo_i[REG_AW-1:0];
  // dword aligned; upper bits come from the high word
  assign mem_addr_o = {hi_i[HI_W-1:0], lo_i[DATA_W-1:2], 2'b00};
endmodule

// File: rtl/pcu_pause_timer.sv
module pcu_pause_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= value_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/poll_cond_unit.sv
module poll_cond_unit
  import pcu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 16,
  parameter int unsigned MEM_AW = 48,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_mode_i,
  input  logic [DATA_W-1:0] cmd_ctrl_i,
  input  logic [DATA_W-1:0] poll_lo_i,
  input  logic [DATA_W-1:0] poll_hi_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [CNT_W-1:0]  interval_i,
  input  logic [DATA_W-1:0] wr_lo_i,
  input  logic [DATA_W-1:0] wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o
);
  pcu_state_e state_q, state_d;

  logic              mode_q, poll_mem_q, wr_mem_q;
  cmp_fn_e           fn_q;
  logic [DATA_W-1:0] plo_q, phi_q, wlo_q, whi_q;
  logic [DATA_W-1:0] ref_q, mask_q, wdata_q, poll_q;
  logic [CNT_W-1:0]  ivl_q;
  logic              done_q;

  logic [REG_AW-1:0] poll_reg_addr, wr_reg_addr;
  logic [MEM_AW-1:0] poll_mem_addr, wr_mem_addr;
  logic              hit, expired, acc_ack, in_write;

  pcu_addr_form #(.DATA_W(DATA_W), .REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_poll_addr (
    .lo_i(plo_q), .hi_i(phi_q), .reg_addr_o(poll_reg_addr), .mem_addr_o(poll_mem_addr)
  );

  pcu_addr_form #(.DATA_W(DATA_W), .REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_wr_addr (
    .lo_i(wlo_q), .hi_i(whi_q), .reg_addr_o(wr_reg_addr), .mem_addr_o(wr_mem_addr)
  );

  pcu_compare #(.DATA_W(DATA_W)) u_cmp (
    .fn_i(fn_q), .poll_i(poll_q), .ref_i(ref_q), .mask_i(mask_q), .hit_o(hit)
  );

  pcu_pause_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(state_q == ST_EVAL), .value_i(ivl_q),
    .run_i(state_q == ST_PAUSE), .expired_o(expired)
  );

  assign in_write = (state_q == ST_WRITE);
  assign acc_ack  = (in_write ? wr_mem_q : poll_mem_q) ? mem_ack_i : reg_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid_i) state_d = ST_READ;
      ST_READ:  if (acc_ack) state_d = ST_EVAL;
      ST_EVAL: begin
        if (mode_q == MODE_WAIT) state_d = hit ? ST_IDLE : ST_PAUSE;
        else                     state_d = hit ? ST_WRITE : ST_IDLE;
      end
      ST_PAUSE: if (expired) state_d = ST_READ;
      ST_WRITE: if (acc_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_WAIT;
      fn_q       <= CMP_ALWAYS;
      poll_mem_q <= 1'b0;
      wr_mem_q   <= 1'b0;
      plo_q      <= '0;
      phi_q      <= '0;
      wlo_q      <= '0;
      whi_q      <= '0;
      ref_q      <= '0;
      mask_q     <= '0;
      wdata_q    <= '0;
      ivl_q      <= '0;
      poll_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ((state_q == ST_EVAL) && ((mode_q == MODE_WAIT) ? hit : !hit))
              || (in_write && acc_ack);
      if (state_q == ST_IDLE && cmd_valid_i) begin
        mode_q     <= cmd_mode_i;
        fn_q       <= cmp_fn_e'(cmd_ctrl_i[FN_LSB +: FN_W]);
        poll_mem_q <= cmd_ctrl_i[POLL_SPACE_BIT];
        wr_mem_q   <= cmd_ctrl_i[WR_SPACE_BIT];
        plo_q      <= poll_lo_i;
        phi_q      <= poll_hi_i;
        wlo_q      <= wr_lo_i;
        whi_q      <= wr_hi_i;
        ref_q      <= ref_i;
        mask_q     <= mask_i;
        wdata_q    <= wr_data_i;
        ivl_q      <= interval_i;
      end
      if (state_q == ST_READ && acc_ack)
        poll_q <= poll_mem_q ? mem_rdata_i : reg_rdata_i;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign reg_req_o   = ((state_q == ST_READ) && !poll_mem_q) || (in_write && !wr_mem_q);
  assign mem_req_o   = ((state_q == ST_READ) &&  poll_mem_q) || (in_write &&  wr_mem_q);
  assign reg_we_o    = in_write;
  assign mem_we_o    = in_write;
  assign reg_addr_o  = in_write ? wr_reg_addr : poll_reg_addr;
  assign mem_addr_o  = in_write ? wr_mem_addr : poll_mem_addr;
  assign reg_wdata_o = wdata_q;
  assign mem_wdata_o = wdata_q;
  assign done_o      = done_q;
endmodule

// File: rtl/poll_cond_unit_chk.sv
module poll_cond_unit_chk #(
  parameter int unsigned REG_AW = 16,
  parameter int unsigned MEM_AW = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              reg_req_o,
  input logic              reg_ack_i,
  input logic [REG_AW-1:0] reg_addr_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              done_o
);
  // R10
  one_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_req_o, mem_req_o}));

  // R10
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o));

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  // R11
  ready_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> done_o);
endmodule

bind poll_cond_unit poll_cond_unit_chk #(.REG_AW(REG_AW), .MEM_AW(MEM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o),
  .reg_req_o(reg_req_o), .reg_ack_i(reg_ack_i), .reg_addr_o(reg_addr_o),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .done_o(done_o)
);

// File: tb/poll_cond_unit_test.sv
module poll_cond_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_mode_i = 1'b0;
  logic [31:0] cmd_ctrl_i = '0, poll_lo_i = '0, poll_hi_i = '0, ref_i = '0, mask_i = '0;
  logic [15:0] interval_i = '0;
  logic [31:0] wr_lo_i = '0, wr_hi_i = '0, wr_data_i = '0;
  logic        reg_req_o, reg_we_o, mem_req_o, mem_we_o, done_o;
  logic [15:0] reg_addr_o;
  logic [47:0] mem_addr_o;
  logic [31:0] reg_wdata_o, mem_wdata_o;
  logic        reg_ack_i = 1'b0, mem_ack_i = 1'b0;
  logic [31:0] reg_rdata_i = '0, mem_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  poll_cond_unit uut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_mode_i, .cmd_ctrl_i,
    .poll_lo_i, .poll_hi_i, .ref_i, .mask_i, .interval_i, .wr_lo_i, .wr_hi_i,
    .wr_data_i, .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o, .reg_ack_i,
    .reg_rdata_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
    .mem_rdata_i, .done_o
  );

  typedef struct {
    int          reads;
    bit          rd_mem;
    logic [47:0] raddr;
    bit          do_write;
    bit          wr_mem;
    logic [47:0] waddr;
    logic [31:0] wdata;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0, fails = 0;

  // model state
  int          reads_seen, writes_seen, bad_reads, gap, exp_gap;
  bit          gap_armed, last_rd_mem, last_wr_mem, done_seen;
  logic [47:0] last_raddr, last_waddr;
  logic [31:0] last_wdata, poll_good, poll_bad;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ref_cmp(input logic [2:0] fn, input logic [31:0] p, input logic [31:0] r, input logic [31:0] m);
    logic [31:0] a = p & m, b = r & m;
    case (fn)
      3'd0: return 1'b1;
      3'd1: return a < b;
      3'd2: return a <= b;
      3'd3: return a == b;
      3'd4: return a != b;
      3'd5: return a >= b;
      3'd6: return a > b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [47:0] form(input bit mem, input logic [31:0] lo, input logic [31:0] hi);
    return mem ? {hi[15:0], lo[31:2], 2'b00} : {32'h0, lo[15:0]};
  endfunction

  // bus model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (reg_ack_i || mem_ack_i) begin
        reg_ack_i = 1'b0;
        mem_ack_i = 1'b0;
        if (!reg_req_o && !mem_req_o) gap++;
      end else if (reg_req_o || mem_req_o) begin
        automatic bit m  = mem_req_o;
        automatic bit we = m ? mem_we_o : reg_we_o;
        if (we) begin
          writes_seen++;
          last_wr_mem = m;
          last_waddr  = m ? mem_addr_o : {32'h0, reg_addr_o};
          last_wdata  = m ? mem_wdata_o : reg_wdata_o;
          gap_armed   = 1'b0;
        end else begin
          if (gap_armed) chk(gap == exp_gap, "R9 pause gap", gap, exp_gap);
          reads_seen++;
          last_rd_mem = m;
          last_raddr  = m ? mem_addr_o : {32'h0, reg_addr_o};
          reg_rdata_i = (reads_seen > bad_reads) ? poll_good : poll_bad;
          mem_rdata_i = reg_rdata_i;
          gap_armed   = 1'b1;
          gap         = 0;
        end
        if (m) mem_ack_i = 1'b1; else reg_ack_i = 1'b1;
      end else begin
        gap++;
      end
      if (done_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          automatic exp_t e = exp_q.pop_front();
          chk(reads_seen == e.reads, {e.tag, " read count"}, reads_seen, e.reads);
          chk(last_rd_mem == e.rd_mem && last_raddr == e.raddr, {e.tag, " poll address"},
              {last_rd_mem, last_raddr}, {e.rd_mem, e.raddr});
          chk(writes_seen == int'(e.do_write), {e.tag, " write count"}, writes_seen, e.do_write);
          if (e.do_write)
            chk(last_wr_mem == e.wr_mem && last_waddr == e.waddr && last_wdata == e.wdata,
                {e.tag, " write target"}, {last_wr_mem, last_waddr},
                {e.wr_mem, e.waddr});
        end
        done_seen = 1'b1;
      end
    end
  end

  task automatic run_cmd(input bit mode, input logic [31:0] ctrl, input logic [31:0] plo, input logic [31:0] phi,
                         input logic [31:0] rv, input logic [31:0] mk, input logic [15:0] ivl,
                         input logic [31:0] wlo, input logic [31:0] whi, input logic [31:0] wd,
                         input logic [31:0] pgood, input logic [31:0] pbad, input int nbad, input string tag);
    exp_t e;
    bit hit = ref_cmp(ctrl[2:0], pgood, rv, mk);
    e.reads    = mode ? 1 : nbad + 1;
    e.rd_mem   = ctrl[4];
    e.raddr    = form(ctrl[4], plo, phi);
    e.do_write = mode && hit;
    e.wr_mem   = ctrl[8];
    e.waddr    = form(ctrl[8], wlo, whi);
    e.wdata    = wd;
    e.tag      = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
    reads_seen = 0; writes_seen = 0; gap_armed = 1'b0; done_seen = 1'b0;
    bad_reads = mode ? 0 : nbad; poll_good = pgood; poll_bad = pbad; exp_gap = ivl + 2;
    cmd_mode_i = mode; cmd_ctrl_i = ctrl; poll_lo_i = plo; poll_hi_i = phi;
    ref_i = rv; mask_i = mk; interval_i = ivl; wr_lo_i = wlo; wr_hi_i = whi; wr_data_i = wd;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    cmd_ctrl_i = 32'hFFFF_FFFF; ref_i = '0; wr_data_i = '0; // later input changes ignored
    while (!done_seen) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(cmd_ready_o == 1'b1, "R11 ready after reset", cmd_ready_o, 1);
    chk(!reg_req_o && !mem_req_o, "R11 no request in reset", {reg_req_o, mem_req_o}, 0);
    chk(done_o == 1'b0, "R11 done low in reset", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cmd_ready_o && !reg_req_o && !mem_req_o && !done_o, "R11 idle after reset release",
        {cmd_ready_o, reg_req_o, mem_req_o, done_o}, 4'b1000);

    // R1 R2 R7: every code, poll below/equal/above reference, register poll and write
    for (int fn = 0; fn < 8; fn++) begin
      for (int k = 0; k < 3; k++) begin
        automatic logic [31:0] pv = (k == 0) ? 32'd5 : (k == 1) ? 32'd9 : 32'd13;
        run_cmd(1'b1, {29'h0, 3'(fn)}, 32'h0000_0020, 32'h0, 32'd9, 32'hFFFF_FFFF, 16'd0,
                32'h0000_0030, 32'h0, 32'hC0DE_0000 | fn, pv, pv, 0,
                (fn == 7) ? "R2 code seven" : "R1 R7 compare code");
      end
    end

    // R3 mask hides high bits
    run_cmd(1'b1, 32'd3, 32'h40, 32'h0, 32'hCD99_0034, 32'h0000_FFFF, 16'd0,
            32'h44, 32'h0, 32'h1111_2222, 32'hAB12_0034, 32'hAB12_0034, 0, "R3 mask equal");
    run_cmd(1'b1, 32'd4, 32'h40, 32'h0, 32'hCD99_0034, 32'h0000_FFFF, 16'd0,
            32'h44, 32'h0, 32'h3333_4444, 32'hAB12_0034, 32'hAB12_0034, 0, "R3 mask not equal");
    // R1 unsigned
    run_cmd(1'b1, 32'd6, 32'h40, 32'h0, 32'h1, 32'hFFFF_FFFF, 16'd0,
            32'h44, 32'h0, 32'h5555_6666, 32'h8000_0000, 32'h8000_0000, 0, "R1 unsigned greater");
    // R4 register address truncation, R5 memory poll address
    run_cmd(1'b1, 32'd0, 32'hDEAD_0044, 32'hFFFF_FFFF, 32'h0, 32'h0, 16'd0,
            32'hFFFF_0010, 32'h0, 32'h7777_8888, 32'h0, 32'h0, 0, "R4 register poll address");
    run_cmd(1'b1, 32'h0000_0010, 32'h1234_567B, 32'hFFFF_00A5, 32'h0, 32'h0, 16'd0,
            32'hFFFF_0010, 32'h0, 32'h9999_AAAA, 32'h0, 32'h0, 0, "R5 memory poll address");
    // R6 memory write space
    run_cmd(1'b1, 32'h0000_0110, 32'h0000_0103, 32'h0, 32'h0, 32'h0, 16'd0,
            32'h0000_1003, 32'h0001_0002, 32'hBEEF_F00D, 32'h0, 32'h0, 0, "R6 memory write");

    // R8 R9 wait mode with retries
    run_cmd(1'b0, 32'h0000_0013, 32'h2000_0008, 32'h0000_0001, 32'h55, 32'hFF, 16'd4,
            32'h0, 32'h0, 32'h0, 32'h1234_5655, 32'h1234_5600, 3, "R8 R9 wait memory");
    run_cmd(1'b0, 32'h0000_0104, 32'h0000_0050, 32'h0, 32'h7, 32'hF, 16'd0,
            32'h60, 32'h0, 32'hAAAA_AAAA, 32'h0000_0008, 32'h0000_0017, 2, "R8 R9 wait zero pause");
    run_cmd(1'b0, 32'd1, 32'h0000_0050, 32'h0, 32'h10, 32'hFFFF_FFFF, 16'd9,
            32'h60, 32'h0, 32'hAAAA_AAAA, 32'h3, 32'h3, 0, "R8 wait first hit");

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R11 all commands done", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule